// File: doc/BRIEF.md
# Write Buffer with Read Bypass

This block sits between a cache and a slower memory port. Stores from the processor side are held in a small first-in first-out queue. One entry at a time is drained to memory. Read misses from the cache also pass through the block on their way to memory. Queued stores therefore never delay a read that does not depend on them.

Every incoming read address is compared against all live queue entries. If nothing matches, the read is sent to memory ahead of any queued store. If an entry matches, the newest matching data is returned straight from the queue, and memory is not touched. A dirty victim line can be pushed into the queue just before the miss that evicted it. The miss then reaches memory first, and the victim write follows.

Top module: `wbuf_read_bypass`

## Requirements
- R1: While reset is held and right after it is released, the queue is empty: wr_ready=1, rd_ready=1, mem_req_valid=0, rd_rsp_valid=0.
- R2: A store is taken on a cycle with wr_valid=1 and wr_ready=1. wr_ready is 0 exactly when DEPTH entries (default 4) are held, so the processor stalls only on a full queue.
- R3: Queued stores reach memory strictly in arrival order. Each is presented with mem_req_write=1 and leaves the queue on a cycle with mem_req_valid=1 and mem_req_ready=1.
- R4: An accepted read with no matching queued address is presented to memory with mem_req_write=0 from the next cycle on. Its data comes back on rd_rsp_data with rd_rsp_hit=0, one cycle after mem_rsp_valid.
- R5: An accepted read whose address matches a queued entry gets rd_rsp_valid=1 and rd_rsp_hit=1 on the next cycle. It carries the data of the newest matching entry and issues no memory request.
- R6: The compare uses the queue contents as they stand before the acceptance edge. A store accepted in the same cycle counts as younger and is not seen. An entry drained in that same cycle is still seen.
- R7: While a read waits for memory, memory is offered the read and never a queued store; a pending read wins over a pending drain in the same cycle.
- R8: A store taken and a drain in the same cycle leave the occupancy unchanged.
- R9: Only one read is in flight. rd_ready is 0 from the acceptance of a missing read until its response has been delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Store request from processor side |
| wr_ready | output | 1 | Queue can take a store |
| wr_addr | input | AW | Store address |
| wr_data | input | DW | Store data |
| rd_valid | input | 1 | Read miss request |
| rd_ready | output | 1 | Block can take a read |
| rd_addr | input | AW | Read address |
| rd_rsp_valid | output | 1 | Read response strobe |
| rd_rsp_hit | output | 1 | 1 when the response came from the queue |
| rd_rsp_data | output | DW | Read response data |
| mem_req_valid | output | 1 | Request offered to memory |
| mem_req_ready | input | 1 | Memory takes the request this cycle |
| mem_req_write | output | 1 | 1 for a store drain, 0 for a read |
| mem_req_addr | output | AW | Request address |
| mem_req_wdata | output | DW | Store data for a drain |
| mem_rsp_valid | input | 1 | Memory read data valid |
| mem_rsp_data | input | DW | Memory read data |

## Verification
Several pairs of this block's functions can fall in the same cycle. A read can be accepted on the very edge where the matching head entry drains. A store and a read to the same address can be accepted together. A store can enter while another leaves. A pending read and a non-empty queue can compete for the memory port. The bench provokes each of these pairs with back-to-back directed calls and with a stretch of pseudo-random traffic under a stuttering memory ready. It judges them against a program-order model of memory and a shadow queue, both kept from the observed handshakes. The model yields the expected data and hit flag of every read, the order of drains, and the stall level of wr_ready.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;
    // Progress of the single in-flight read.
    typedef enum logic [1:0] {
        RD_IDLE = 2'd0,   // no read held
        RD_PEND = 2'd1,   // missed the queue, waiting for the memory port
        RD_WAIT = 2'd2    // issued, waiting for memory data
    } rd_state_e;
endpackage

// File: rtl/wbuf_match.sv
// Associative search over the live queue entries; newest match wins.
module wbuf_match #(
    parameter int AW    = 8,
    parameter int DW    = 16,
    parameter int DEPTH = 4
) (
    input  logic [DEPTH-1:0][AW-1:0]        ent_addr,
    input  logic [DEPTH-1:0][DW-1:0]        ent_data,
    input  logic [$clog2(DEPTH)-1:0]        head,
    input  logic [$clog2(DEPTH+1)-1:0]      count,
    input  logic [AW-1:0]                   look_addr,
    output logic                            hit,
    output logic [DW-1:0]                   hit_data
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH+1);

    logic [DEPTH-1:0][PTR_W-1:0] age_idx;   // slot holding the k-th oldest entry
    logic [DEPTH-1:0]            age_hit;

    for (genvar k = 0; k < DEPTH; k++) begin : g_age
        assign age_idx[k] = PTR_W'((32'(head) + k) % DEPTH);
        assign age_hit[k] = (CNT_W'(k) < count) && (ent_addr[age_idx[k]] == look_addr);
    end

    always_comb begin
        hit      = 1'b0;
        hit_data = '0;
        for (int k = 0; k < DEPTH; k++) begin
            if (age_hit[k]) begin       // later (younger) matches override
                hit      = 1'b1;
                hit_data = ent_data[age_idx[k]];
            end
        end
    end
endmodule

// File: rtl/wbuf_arb.sv
// Memory port arbiter: a held read always goes before a queued store.
module wbuf_arb #(
    parameter int AW = 8,
    parameter int DW = 16
) (
    input  logic          rd_pend,
    input  logic [AW-1:0] rd_addr,
    input  logic          wb_nonempty,
    input  logic [AW-1:0] head_addr,
    input  logic [DW-1:0] head_data,
    input  logic          mem_req_ready,
    output logic          mem_req_valid,
    output logic          mem_req_write,
    output logic [AW-1:0] mem_req_addr,
    output logic [DW-1:0] mem_req_wdata,
    output logic          rd_issue,
    output logic          drain
);
    always_comb begin
        mem_req_valid = rd_pend || wb_nonempty;
        mem_req_write = !rd_pend && wb_nonempty;
        mem_req_addr  = rd_pend ? rd_addr : head_addr;
        mem_req_wdata = rd_pend ? '0 : head_data;
        rd_issue      = rd_pend && mem_req_ready;
        drain         = mem_req_write && mem_req_ready;
    end
endmodule

// File: rtl/wbuf_read_bypass.sv
module wbuf_read_bypass #(
    parameter int AW    = 8,
    parameter int DW    = 16,
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_valid,
    output logic          wr_ready,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_valid,
    output logic          rd_ready,
    input  logic [AW-1:0] rd_addr,
    output logic          rd_rsp_valid,
    output logic          rd_rsp_hit,
    output logic [DW-1:0] rd_rsp_data,
    output logic          mem_req_valid,
    input  logic          mem_req_ready,
    output logic          mem_req_write,
    output logic [AW-1:0] mem_req_addr,
    output logic [DW-1:0] mem_req_wdata,
    input  logic          mem_rsp_valid,
    input  logic [DW-1:0] mem_rsp_data
);
    import wbuf_pkg::*;

    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH+1);

    typedef struct packed {
        logic [DEPTH-1:0][AW-1:0] addr;
        logic [DEPTH-1:0][DW-1:0] data;
        logic [PTR_W-1:0]         head;
        logic [CNT_W-1:0]         count;
        rd_state_e                rds;
        logic [AW-1:0]            rd_addr;
        logic                     rsp_valid;
        logic                     rsp_hit;
        logic [DW-1:0]            rsp_data;
    } state_t;

    state_t s_q, s_d;

    logic             look_hit;
    logic [DW-1:0]    look_data;
    logic             rd_issue, drain, enq, rd_acc;
    logic [PTR_W-1:0] tail;

    wbuf_match #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_match (
        .ent_addr  (s_q.addr),
        .ent_data  (s_q.data),
        .head      (s_q.head),
        .count     (s_q.count),
        .look_addr (rd_addr),
        .hit       (look_hit),
        .hit_data  (look_data)
    );

    wbuf_arb #(.AW(AW), .DW(DW)) u_arb (
        .rd_pend       (s_q.rds == RD_PEND),
        .rd_addr       (s_q.rd_addr),
        .wb_nonempty   (s_q.count != '0),
        .head_addr     (s_q.addr[s_q.head]),
        .head_data     (s_q.data[s_q.head]),
        .mem_req_ready (mem_req_ready),
        .mem_req_valid (mem_req_valid),
        .mem_req_write (mem_req_write),
        .mem_req_addr  (mem_req_addr),
        .mem_req_wdata (mem_req_wdata),
        .rd_issue      (rd_issue),
        .drain         (drain)
    );

    assign wr_ready     = (s_q.count != CNT_W'(DEPTH));
    assign rd_ready     = (s_q.rds == RD_IDLE);
    assign enq          = wr_valid && wr_ready;
    assign rd_acc       = rd_valid && rd_ready;
    assign tail         = PTR_W'((32'(s_q.head) + 32'(s_q.count)) % DEPTH);
    assign rd_rsp_valid = s_q.rsp_valid;
    assign rd_rsp_hit   = s_q.rsp_hit;
    assign rd_rsp_data  = s_q.rsp_data;

    always_comb begin
        s_d           = s_q;
        s_d.rsp_valid = 1'b0;

        // queue: write at tail, retire at head
        if (enq) begin
            s_d.addr[tail] = wr_addr;
            s_d.data[tail] = wr_data;
        end
        if (drain) begin
            s_d.head = PTR_W'((32'(s_q.head) + 1) % DEPTH);
        end
        s_d.count = s_q.count + CNT_W'(enq) - CNT_W'(drain);

        // read path
        unique case (s_q.rds)
            RD_IDLE: begin
                if (rd_acc) begin
                    if (look_hit) begin
                        s_d.rsp_valid = 1'b1;
                        s_d.rsp_hit   = 1'b1;
                        s_d.rsp_data  = look_data;
                    end else begin
                        s_d.rds     = RD_PEND;
                        s_d.rd_addr = rd_addr;
                    end
                end
            end
            RD_PEND: begin
                if (rd_issue) s_d.rds = RD_WAIT;
            end
            RD_WAIT: begin
                if (mem_rsp_valid) begin
                    s_d.rds       = RD_IDLE;
                    s_d.rsp_valid = 1'b1;
                    s_d.rsp_hit   = 1'b0;
                    s_d.rsp_data  = mem_rsp_data;
                end
            end
            default: s_d.rds = RD_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q     <= '0;
            s_q.rds <= RD_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    // occupancy never exceeds the queue depth
    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.count <= CNT_W'(DEPTH));

    // head advances by one slot per drain
    assert_drain_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
        drain |=> (s_q.head == PTR_W'((32'($past(s_q.head)) + 1) % DEPTH)));

    // a held read is what memory is offered
    assert_pend_offered_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.rds == RD_PEND) |-> (mem_req_valid && mem_req_addr == s_q.rd_addr));

    // a queue hit answers on the next cycle
    assert_hit_reply_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_acc && look_hit) |=> (rd_rsp_valid && rd_rsp_hit));

    // no store slips ahead of a held read
    assert_read_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.rds == RD_PEND) |-> !mem_req_write);

    // simultaneous enqueue and drain keep the count
    assert_steady_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (enq && drain) |=> (s_q.count == $past(s_q.count)));

    // a missing read blocks further reads
    assert_single_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_acc && !look_hit) |=> !rd_ready);
endmodule

// File: tb/tb_wbuf_read_bypass.sv
module tb_wbuf_read_bypass;
    localparam int AW = 8;
    localparam int DW = 16;
    localparam int DEPTH = 4;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n = 1'b0;
    logic wr_valid = 1'b0, rd_valid = 1'b0;
    logic [AW-1:0] wr_addr = '0, rd_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic mem_req_ready = 1'b0, mem_rsp_valid = 1'b0;
    logic [DW-1:0] mem_rsp_data = '0;
    logic wr_ready, rd_ready, rd_rsp_valid, rd_rsp_hit;
    logic [DW-1:0] rd_rsp_data, mem_req_wdata;
    logic mem_req_valid, mem_req_write;
    logic [AW-1:0] mem_req_addr;

    wbuf_read_bypass #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) dut (.*);

    int n_chk = 0, n_bad = 0;
    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // scoreboard and models
    logic [DW-1:0] exp_data_q[$];
    bit            exp_hit_q[$];
    logic [AW-1:0] sh_addr[$];
    logic [DW-1:0] sh_data[$];
    logic [DW-1:0] arch   [2**AW];
    logic [DW-1:0] memarr [2**AW];
    bit rd_out = 0, rd_unissued = 0, live = 0, auto_rdy = 0;
    logic [AW-1:0] miss_addr = '0;
    int rsp_delay = 0;
    logic [DW-1:0] rsp_buf = '0;
    logic [15:0] rl = 16'hACE1;

    // monitor: mid-cycle sampling of everything that fires at the next edge
    always @(negedge clk) if (live) begin
        bit new_miss, h;
        logic [DW-1:0] d;
        new_miss = 0;
        if (rd_rsp_valid) begin
            if (exp_data_q.size() == 0) chk(0, "R4 unexpected response", 1, 0);
            else begin
                d = exp_data_q.pop_front();
                h = exp_hit_q.pop_front();
                chk(rd_rsp_data == d, h ? "R5 buffer data" : "R4 memory data", rd_rsp_data, d);
                chk(rd_rsp_hit == h, "R5 hit flag", rd_rsp_hit, h);
            end
            rd_out = 0;
        end
        chk(rd_ready == !rd_out, "R9 rd_ready", rd_ready, !rd_out);
        chk(wr_ready == (sh_addr.size() < DEPTH), "R2 wr_ready", wr_ready, sh_addr.size() < DEPTH);
        if (rd_unissued)
            chk(mem_req_valid && !mem_req_write, "R7 read ahead of drain", {mem_req_valid, mem_req_write}, 2'b10);
        else if (mem_req_valid)
            chk(mem_req_write, "R5 no memory read for hit", mem_req_write, 1);
        // read acceptance compares against the queue before this edge (R6)
        if (rd_valid && rd_ready) begin
            h = 0;
            foreach (sh_addr[i]) if (sh_addr[i] == rd_addr) h = 1;
            exp_data_q.push_back(arch[rd_addr]);
            exp_hit_q.push_back(h);
            if (!h) begin new_miss = 1; rd_out = 1; miss_addr = rd_addr; end
        end
        if (wr_valid && wr_ready) begin
            sh_addr.push_back(wr_addr);
            sh_data.push_back(wr_data);
            arch[wr_addr] = wr_data;
        end
        if (mem_req_valid && mem_req_ready) begin
            if (mem_req_write) begin
                if (sh_addr.size() == 0) chk(0, "R3 drain from empty queue", 1, 0);
                else begin
                    chk(mem_req_addr == sh_addr[0], "R3 drain address order", mem_req_addr, sh_addr[0]);
                    chk(mem_req_wdata == sh_data[0], "R3 drain data order", mem_req_wdata, sh_data[0]);
                    memarr[mem_req_addr] = mem_req_wdata;
                    void'(sh_addr.pop_front());
                    void'(sh_data.pop_front());
                end
            end else begin
                chk(mem_req_addr == miss_addr, "R4 read address", mem_req_addr, miss_addr);
                rsp_buf = memarr[mem_req_addr];
                rsp_delay = 2;
                rd_unissued = 0;
            end
        end
        if (new_miss) rd_unissued = 1;
    end

    // memory model: response two edges after acceptance, optional stutter
    always @(posedge clk) begin
        #1;
        mem_rsp_valid = 1'b0;
        if (rsp_delay > 0) begin
            rsp_delay--;
            if (rsp_delay == 0) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = rsp_buf;
            end
        end
        if (auto_rdy) mem_req_ready = rl[0] | rl[2];
        rl = {rl[14:0], rl[15] ^ rl[13] ^ rl[12] ^ rl[10]};
    end

    task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        wr_addr = a; wr_data = d; wr_valid = 1'b1;
        do @(negedge clk); while (!wr_ready);
        @(posedge clk); #1 wr_valid = 1'b0;
    endtask

    task automatic do_read(input logic [AW-1:0] a);
        rd_addr = a; rd_valid = 1'b1;
        do @(negedge clk); while (!rd_ready);
        @(posedge clk); #1 rd_valid = 1'b0;
    endtask

    task automatic do_both(input logic [AW-1:0] wa, input logic [DW-1:0] wd, input logic [AW-1:0] ra);
        wr_addr = wa; wr_data = wd; rd_addr = ra;
        wr_valid = 1'b1; rd_valid = 1'b1;
        do @(negedge clk); while (!(wr_ready && rd_ready));
        @(posedge clk); #1 begin wr_valid = 1'b0; rd_valid = 1'b0; end
    endtask

    task automatic wait_idle();
        do begin @(negedge clk); #1; end
        while (sh_addr.size() != 0 || rd_out || exp_data_q.size() != 0);
        @(posedge clk); #1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 100000, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 2**AW; i++) begin
            arch[i]   = {8'hA5, 8'(i)};
            memarr[i] = {8'hA5, 8'(i)};
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(wr_ready && rd_ready, "R1 ready in reset", {wr_ready, rd_ready}, 2'b11);
        chk(!mem_req_valid && !rd_rsp_valid, "R1 idle in reset", {mem_req_valid, rd_rsp_valid}, 0);
        @(posedge clk); #1 rst_n = 1'b1;
        @(negedge clk);
        chk(!mem_req_valid && wr_ready, "R1 empty after reset", {mem_req_valid, wr_ready}, 2'b01);
        live = 1;
        @(posedge clk); #1;

        // fill with memory stalled, then hit on duplicates (newest wins)
        mem_req_ready = 1'b0;
        do_write(8'h10, 16'h1111);
        do_write(8'h11, 16'h2222);
        do_write(8'h10, 16'h3333);
        do_write(8'h12, 16'h4444);
        @(negedge clk);
        chk(!wr_ready, "R2 stall when full", wr_ready, 0);
        @(posedge clk); #1;
        do_read(8'h10);               // R5: expect 3333, hit
        do_read(8'h11);               // R5: expect 2222, hit
        do_read(8'h50);               // R4/R7: miss, held while queue is full
        repeat (3) @(posedge clk);
        #1 mem_req_ready = 1'b1;       // read must leave before the four stores
        wait_idle();

        // R6: store and read of one address in the same cycle; read sees the older value
        mem_req_ready = 1'b0;
        do_both(8'h10, 16'h5555, 8'h10);
        repeat (2) @(posedge clk);
        #1 mem_req_ready = 1'b1;
        wait_idle();

        // R6: read hits the entry that drains on the same edge
        do_write(8'h30, 16'h6666);
        do_read(8'h30);
        wait_idle();

        // victim store then the evicting miss
        do_write(8'h60, 16'h7777);
        do_read(8'h61);
        wait_idle();

        // R8: back-to-back stores with memory always ready keep occupancy at one
        for (int i = 0; i < 6; i++) do_write(8'h70 + 8'(i), 16'h8000 + 16'(i));
        @(negedge clk);
        chk(sh_addr.size() <= 1 && wr_ready, "R8 steady occupancy", sh_addr.size(), 1);
        @(posedge clk); #1;
        wait_idle();

        // mixed traffic with a stuttering memory
        auto_rdy = 1;
        for (int i = 0; i < 120; i++) begin
            logic [15:0] r;
            r = rl ^ 16'(i * 40503);
            if (r[3:2] != 2'd3) do_write(8'h20 + 8'(r[5:4]), r);
            else                do_read(8'h20 + 8'(r[6:4]));
        end
        auto_rdy = 0;
        mem_req_ready = 1'b1;
        wait_idle();
        chk(exp_data_q.size() == 0, "R4 all reads answered", exp_data_q.size(), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule